// File: doc/BRIEF.md
# Remote Terminal Built-In-Test Word

This block keeps the 16-bit built-in-test word of a dual-redundant serial-bus remote terminal. Most fields are sticky error flags. Some are set by single-cycle error pulses from the transmitter, the subsystem handshake logic and the loop-back checker. Others come from a judgement of each decoded command as it arrives. Three fields track the shutdown state of each bus and the terminal-flag inhibit state. The block also gives an illegal-command indication, which the status-word logic uses as its message-error bit.

Each valid command is checked in a single cycle. The check covers its T/R bit against the direction its mode code requires, reserved mode codes against the subsystem's reject line, the subsystem's illegal-command line, transmit requests sent to the broadcast address, and the selected-transmitter shutdown codes. Legal mode commands that read terminal state change nothing. A legal reset-remote-terminal command clears the error fields. A legal initiate-self-test command starts a window counter, and that counter checks when the transmitter timeout trips.

Top module: `bitw_word`

## Requirements
- R1: While `rst_n` is low, `bit_word` and `msg_illegal` are zero. Bits 10, 14 and 15 of `bit_word` are always zero.
- R2: Bits 8, 9 and 11 of `bit_word` equal `bus0_off`, `bus1_off` and `tf_inhibit` as sampled at the previous clock edge.
- R3: A `tx_timeout` pulse sets bit 0. It also sets bit 12 when `tx_bus`=0 or bit 13 when `tx_bus`=1. `hs_fail` sets bit 1 and `loop_fail` sets bit 2. These bits stay set until a reset or a legal reset-remote-terminal command.
- R4: A valid mode command (`cmd_mode`=1) with a non-reserved code whose `cmd_tr` is wrong sets bit 3. Reserved codes are 01001–01111 and 10110–11111. Codes 10001, 10100 and 10101 require `cmd_tr`=0. All other non-reserved codes require `cmd_tr`=1.
- R5: A valid command sets bit 4 in three cases: `ss_illegal_n` is low; it is a mode command with a reserved code while `ss_allow_rsvd` is high; or it is mode code 10100 or 10101 (with the default `SEL_SD_LEGAL`=0).
- R6: A valid command with `cmd_bcast`=1 sets bit 7 if it requires the terminal to transmit. This means a non-mode command with `cmd_tr`=1, or mode code 00010, 10000, 10010 or 10011.
- R7: A `msg_end` pulse sets bit 5 when `rx_count` < `exp_count` and sets bit 6 when `rx_count` > `exp_count`.
- R8: Every valid command that is not a legal state read (R9) clears bits 5 and 6. Error sets in the same cycle, including those from `msg_end`, still take effect.
- R9: A legal state-read command leaves every event bit and `msg_illegal` unchanged. Such a command has mode code 00010, 10010 or 10011, `cmd_tr`=1, `cmd_bcast`=0, `ss_illegal_n` high, and meets no condition of R4–R6.
- R10: A legal reset-remote-terminal command clears bits 0–7, 12 and 13. It is mode code 01000 with `cmd_tr`=1 that meets no condition of R4–R6. Error pulses in the same cycle still set their bits.
- R11: A legal initiate-self-test command starts a window; it is mode code 00011 with `cmd_tr`=1. Count clock edges after the command's edge as n. Bit 0 is set if `st_trip` arrives at n < `WIN_LO`, or if no trip has arrived by n = `WIN_HI`. A trip with `WIN_LO` ≤ n ≤ `WIN_HI` sets nothing.
- R12: Every valid command other than a legal state read loads `msg_illegal` with 1 if it met any condition of R4–R6, and with 0 otherwise. At all other times `msg_illegal` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up clear, active low |
| cmd_valid | input | 1 | One-cycle strobe: a valid command for this terminal is starting |
| cmd_mode | input | 1 | Command is a mode command |
| cmd_code | input | 5 | Mode code field |
| cmd_tr | input | 1 | T/R bit, 1 = terminal transmits |
| cmd_bcast | input | 1 | Command carries the broadcast address |
| ss_illegal_n | input | 1 | Subsystem declares the command illegal, active low |
| ss_allow_rsvd | input | 1 | When high, reserved mode codes are treated as illegal |
| msg_end | input | 1 | Pulse at the end of a received message |
| rx_count | input | CNT_W | Valid data words received |
| exp_count | input | CNT_W | Data words the command specified |
| tx_timeout | input | 1 | Transmitter timeout pulse |
| tx_bus | input | 1 | Bus that was transmitting (0 or 1) |
| hs_fail | input | 1 | Subsystem handshake failure pulse |
| loop_fail | input | 1 | Loop-back check failure pulse |
| st_trip | input | 1 | Timeout mechanism tripped during self test |
| bus0_off | input | 1 | Bus 0 transmitter is shut down |
| bus1_off | input | 1 | Bus 1 transmitter is shut down |
| tf_inhibit | input | 1 | Terminal flag is inhibited |
| bit_word | output | 16 | Built-in-test word |
| msg_illegal | output | 1 | Last judged command was illegal |

## Verification
A command and a stream of error pulses can hit the register in the same cycle. The main collision is between the clearing of the word-count bits by a new command and a word-count error from `msg_end`. A second is between a reset-remote-terminal command and a loop failure. The bench drives each pair on the same clock edge and checks that the new error survives the clear. A second overlap involves a state-read command that arrives while old errors are stored. Here the bench checks that the stored word and the message-error flag come through the command unchanged.

// File: rtl/bitw_pkg.sv
package bitw_pkg;
   localparam logic [4:0] MC_TX_STATUS  = 5'b00010;
   localparam logic [4:0] MC_SELFTEST   = 5'b00011;
   localparam logic [4:0] MC_RESET_RT   = 5'b01000;
   localparam logic [4:0] MC_TX_VECTOR  = 5'b10000;
   localparam logic [4:0] MC_SYNC_DATA  = 5'b10001;
   localparam logic [4:0] MC_TX_LASTCMD = 5'b10010;
   localparam logic [4:0] MC_TX_BITW    = 5'b10011;
   localparam logic [4:0] MC_SEL_SD     = 5'b10100;
   localparam logic [4:0] MC_SEL_SD_OVR = 5'b10101;

   localparam int B_TXTO = 0;
   localparam int B_HS   = 1;
   localparam int B_LOOP = 2;
   localparam int B_TR   = 3;
   localparam int B_ILC  = 4;
   localparam int B_WCL  = 5;
   localparam int B_WCH  = 6;
   localparam int B_BC   = 7;
   localparam int B_SD0  = 8;
   localparam int B_SD1  = 9;
   localparam int B_TFI  = 11;
   localparam int B_TO0  = 12;
   localparam int B_TO1  = 13;

   typedef struct packed {
      logic status_read;
      logic reset_rt;
      logic self_test;
      logic bad_cmd;
      logic bad_tr;
      logic bad_bcast;
   } cmd_class_t;

   function automatic logic is_reserved(input logic [4:0] c);
      return (c >= 5'd9 && c <= 5'd15) || (c >= 5'd22);
   endfunction

   function automatic logic wants_tr(input logic [4:0] c);
      return !(c == MC_SYNC_DATA || c == MC_SEL_SD || c == MC_SEL_SD_OVR);
   endfunction

   function automatic logic sends_data(input logic [4:0] c);
      return c == MC_TX_STATUS || c == MC_TX_VECTOR ||
             c == MC_TX_LASTCMD || c == MC_TX_BITW;
   endfunction
endpackage

// File: rtl/bitw_cmd_decode.sv
module bitw_cmd_decode import bitw_pkg::*; #(
   parameter bit SEL_SD_LEGAL = 1'b0
) (
   input  logic       cmd_mode,
   input  logic [4:0] cmd_code,
   input  logic       cmd_tr,
   input  logic       cmd_bcast,
   input  logic       ss_illegal_n,
   input  logic       ss_allow_rsvd,
   output cmd_class_t cls
);
   logic rsvd, bad_sd, bad_cmd, bad_tr, bad_bcast, ok;

   assign rsvd = is_reserved(cmd_code);

   generate
      if (SEL_SD_LEGAL) begin : g_sd_legal
         assign bad_sd = 1'b0;
      end else begin : g_sd_illegal
         assign bad_sd = cmd_mode & (cmd_code == MC_SEL_SD || cmd_code == MC_SEL_SD_OVR);
      end
   endgenerate

   assign bad_tr    = cmd_mode & ~rsvd & (cmd_tr != wants_tr(cmd_code));
   assign bad_cmd   = ~ss_illegal_n | (cmd_mode & rsvd & ss_allow_rsvd) | bad_sd;
   assign bad_bcast = cmd_bcast & (cmd_mode ? sends_data(cmd_code) : cmd_tr);
   assign ok        = ~(bad_tr | bad_cmd | bad_bcast);

   always_comb begin
      cls             = '0;
      cls.bad_cmd     = bad_cmd;
      cls.bad_tr      = bad_tr;
      cls.bad_bcast   = bad_bcast;
      cls.status_read = ok & cmd_mode & (cmd_code == MC_TX_STATUS ||
                        cmd_code == MC_TX_LASTCMD || cmd_code == MC_TX_BITW);
      cls.reset_rt    = ok & cmd_mode & (cmd_code == MC_RESET_RT);
      cls.self_test   = ok & cmd_mode & (cmd_code == MC_SELFTEST);
   end
endmodule

// File: rtl/bitw_selftest_win.sv
module bitw_selftest_win #(
   parameter int WIN_LO = 660,
   parameter int WIN_HI = 800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic trip,
   output logic fail
);
   localparam int ST_W = $clog2(WIN_HI + 1);
   localparam logic [ST_W:0] LO_V = (ST_W+1)'(WIN_LO);
   localparam logic [ST_W:0] HI_V = (ST_W+1)'(WIN_HI);

   logic            active_q;
   logic [ST_W-1:0] cnt_q;
   logic [ST_W:0]   n;

   assign n    = {1'b0, cnt_q} + (ST_W+1)'(1);
   assign fail = active_q & (trip ? (n < LO_V) : (n >= HI_V));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (active_q) begin
         if (trip || n >= HI_V) active_q <= 1'b0;
         else                   cnt_q    <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/bitw_word.sv
module bitw_word import bitw_pkg::*; #(
   parameter int CNT_W        = 6,
   parameter int WIN_LO       = 660,
   parameter int WIN_HI       = 800,
   parameter bit SEL_SD_LEGAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_mode,
   input  logic [4:0]       cmd_code,
   input  logic             cmd_tr,
   input  logic             cmd_bcast,
   input  logic             ss_illegal_n,
   input  logic             ss_allow_rsvd,
   input  logic             msg_end,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] exp_count,
   input  logic             tx_timeout,
   input  logic             tx_bus,
   input  logic             hs_fail,
   input  logic             loop_fail,
   input  logic             st_trip,
   input  logic             bus0_off,
   input  logic             bus1_off,
   input  logic             tf_inhibit,
   output logic [15:0]      bit_word,
   output logic             msg_illegal
);
   localparam int WORD_W = 16;
   localparam logic [WORD_W-1:0] EV_MASK = WORD_W'((1 << B_TO1) | (1 << B_TO0) | 16'h00FF);
   localparam logic [WORD_W-1:0] WC_MASK = WORD_W'((1 << B_WCL) | (1 << B_WCH));

   initial begin
      assert (WIN_LO >= 1 && WIN_LO <= WIN_HI) else $error("bitw_word: bad self-test window");
      assert (CNT_W >= 6) else $error("bitw_word: CNT_W must hold 32 words");
   end

   cmd_class_t        cls;
   logic              st_fail, rt_clear, wc_clear, judge;
   logic [WORD_W-1:0] ev_set, kept, nxt, word_q;
   logic              illeg_q;

   bitw_cmd_decode #(.SEL_SD_LEGAL(SEL_SD_LEGAL)) u_dec (
      .cmd_mode     (cmd_mode),
      .cmd_code     (cmd_code),
      .cmd_tr       (cmd_tr),
      .cmd_bcast    (cmd_bcast),
      .ss_illegal_n (ss_illegal_n),
      .ss_allow_rsvd(ss_allow_rsvd),
      .cls          (cls)
   );

   bitw_selftest_win #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
      .clk  (clk),
      .rst_n(rst_n),
      .start(cmd_valid & cls.self_test),
      .trip (st_trip),
      .fail (st_fail)
   );

   assign rt_clear = cmd_valid & cls.reset_rt;
   assign judge    = cmd_valid & ~cls.status_read;
   assign wc_clear = judge;

   always_comb begin
      ev_set         = '0;
      ev_set[B_TXTO] = tx_timeout | st_fail;
      ev_set[B_HS]   = hs_fail;
      ev_set[B_LOOP] = loop_fail;
      ev_set[B_TR]   = cmd_valid & cls.bad_tr;
      ev_set[B_ILC]  = cmd_valid & cls.bad_cmd;
      ev_set[B_WCL]  = msg_end & (rx_count < exp_count);
      ev_set[B_WCH]  = msg_end & (rx_count > exp_count);
      ev_set[B_BC]   = cmd_valid & cls.bad_bcast;
      ev_set[B_TO0]  = tx_timeout & ~tx_bus;
      ev_set[B_TO1]  = tx_timeout & tx_bus;
   end

   always_comb begin
      kept = word_q & EV_MASK;
      if (rt_clear)      kept = '0;
      else if (wc_clear) kept = kept & ~WC_MASK;
      nxt        = kept | ev_set;
      nxt[B_SD0] = bus0_off;
      nxt[B_SD1] = bus1_off;
      nxt[B_TFI] = tf_inhibit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         illeg_q <= 1'b0;
      end else begin
         word_q <= nxt;
         if (judge) illeg_q <= cls.bad_cmd | cls.bad_tr | cls.bad_bcast;
      end
   end

   assign bit_word    = word_q;
   assign msg_illegal = illeg_q;
endmodule

// File: rtl/bitw_word_chk.sv
module bitw_word_chk #(
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             cmd_mode,
   input logic [4:0]       cmd_code,
   input logic             cmd_tr,
   input logic             cmd_bcast,
   input logic             ss_illegal_n,
   input logic             msg_end,
   input logic [CNT_W-1:0] rx_count,
   input logic [CNT_W-1:0] exp_count,
   input logic             hs_fail,
   input logic             loop_fail,
   input logic             bus0_off,
   input logic             bus1_off,
   input logic             tf_inhibit,
   input logic [15:0]      bit_word,
   input logic             msg_illegal
);
   assert_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (bit_word[8] == $past(bus0_off)) && (bit_word[9] == $past(bus1_off))
                && (bit_word[11] == $past(tf_inhibit)));

   assert_loop_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      loop_fail |=> bit_word[2]);

   assert_hs_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_word[1] && !(cmd_valid && cmd_mode && cmd_code == 5'b01000) |=> bit_word[1]);

   assert_ss_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !ss_illegal_n |=> bit_word[4] && msg_illegal);

   assert_bcast_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_mode && cmd_tr && cmd_bcast |=> bit_word[7]);

   assert_wc_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      msg_end && (rx_count > exp_count) |=> bit_word[6]);

   assert_status_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_mode && cmd_code == 5'b00010 && cmd_tr && !cmd_bcast && ss_illegal_n
      && !hs_fail && !loop_fail && !msg_end
      |=> (bit_word[7:1] == $past(bit_word[7:1])) && (msg_illegal == $past(msg_illegal)));
endmodule

bind bitw_word bitw_word_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_mode    (cmd_mode),
   .cmd_code    (cmd_code),
   .cmd_tr      (cmd_tr),
   .cmd_bcast   (cmd_bcast),
   .ss_illegal_n(ss_illegal_n),
   .msg_end     (msg_end),
   .rx_count    (rx_count),
   .exp_count   (exp_count),
   .hs_fail     (hs_fail),
   .loop_fail   (loop_fail),
   .bus0_off    (bus0_off),
   .bus1_off    (bus1_off),
   .tf_inhibit  (tf_inhibit),
   .bit_word    (bit_word),
   .msg_illegal (msg_illegal)
);

// File: tb/bitw_word_tb.sv
module bitw_word_tb;
   localparam int LO = 660;
   localparam int HI = 800;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 0, cmd_mode = 0, cmd_tr = 0, cmd_bcast = 0;
   logic [4:0] cmd_code = '0;
   logic ss_illegal_n = 1, ss_allow_rsvd = 0, msg_end = 0;
   logic [5:0] rx_count = '0, exp_count = '0;
   logic tx_timeout = 0, tx_bus = 0, hs_fail = 0, loop_fail = 0, st_trip = 0;
   logic bus0_off = 0, bus1_off = 0, tf_inhibit = 0;
   logic [15:0] bit_word;
   logic msg_illegal;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [15:0] m_word = '0;
   logic        m_ill = 0;
   bit          m_st_on = 0;
   int          m_st_n = 0;

   always #2 clk = ~clk;

   bitw_word u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
      .cmd_code(cmd_code), .cmd_tr(cmd_tr), .cmd_bcast(cmd_bcast),
      .ss_illegal_n(ss_illegal_n), .ss_allow_rsvd(ss_allow_rsvd), .msg_end(msg_end),
      .rx_count(rx_count), .exp_count(exp_count), .tx_timeout(tx_timeout),
      .tx_bus(tx_bus), .hs_fail(hs_fail), .loop_fail(loop_fail), .st_trip(st_trip),
      .bus0_off(bus0_off), .bus1_off(bus1_off), .tf_inhibit(tf_inhibit),
      .bit_word(bit_word), .msg_illegal(msg_illegal)
   );

   function automatic string req_of(input logic [15:0] d);
      if (d[15] || d[14] || d[10]) return "R1";
      if (d[8] || d[9] || d[11])   return "R2";
      if (d[0])                    return "R3 or R11";
      if (d[1] || d[2] || d[12] || d[13]) return "R3";
      if (d[3]) return "R4";
      if (d[4]) return "R5";
      if (d[7]) return "R6";
      return "R7 or R8";
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // reference model, evaluated once per rising edge from the driven inputs
   task automatic model_edge();
      int c = int'(cmd_code);
      bit rsv, reqtr, iltr, ilc, ilb, ok, srd, rrt, stt, stf;
      logic [15:0] w;
      if (!rst_n) begin
         m_word = '0; m_ill = 0; m_st_on = 0; m_st_n = 0;
         return;
      end
      rsv   = (c >= 9 && c <= 15) || c >= 22;
      reqtr = !(c == 17 || c == 20 || c == 21);
      iltr  = cmd_mode && !rsv && (cmd_tr != reqtr);
      ilc   = !ss_illegal_n || (cmd_mode && rsv && ss_allow_rsvd) || (cmd_mode && (c == 20 || c == 21));
      ilb   = cmd_bcast && (cmd_mode ? (c == 2 || c == 16 || c == 18 || c == 19) : cmd_tr);
      ok    = !iltr && !ilc && !ilb;
      srd   = cmd_mode && ok && (c == 2 || c == 18 || c == 19);
      rrt   = cmd_mode && ok && c == 8;
      stt   = cmd_mode && ok && c == 3;
      stf   = 0;
      if (m_st_on) begin
         int n = m_st_n + 1;
         if (st_trip) begin stf = (n < LO); m_st_on = 0; end
         else if (n >= HI) begin stf = 1; m_st_on = 0; end
         else m_st_n = n;
      end
      if (cmd_valid && stt) begin m_st_on = 1; m_st_n = 0; end
      w = m_word;
      w[8] = 0; w[9] = 0; w[11] = 0;
      if (cmd_valid && rrt) w = '0;
      else if (cmd_valid && !srd) begin w[5] = 0; w[6] = 0; end
      if (tx_timeout || stf) w[0] = 1;
      if (tx_timeout) begin if (tx_bus) w[13] = 1; else w[12] = 1; end
      if (hs_fail) w[1] = 1;
      if (loop_fail) w[2] = 1;
      if (cmd_valid && iltr) w[3] = 1;
      if (cmd_valid && ilc) w[4] = 1;
      if (msg_end && rx_count < exp_count) w[5] = 1;
      if (msg_end && rx_count > exp_count) w[6] = 1;
      if (cmd_valid && ilb) w[7] = 1;
      w[8] = bus0_off; w[9] = bus1_off; w[11] = tf_inhibit;
      m_word = w;
      if (cmd_valid && !srd) m_ill = !ok;
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      #1;
      checks++;
      if (bit_word !== m_word || msg_illegal !== m_ill) begin
         errors++;
         $display("FAIL %s (model compare): actual %h/%b expected %h/%b",
                  (msg_illegal !== m_ill) ? "R12" : req_of(bit_word ^ m_word),
                  bit_word, msg_illegal, m_word, m_ill);
      end
      @(negedge clk);
      cmd_valid = 0; msg_end = 0; tx_timeout = 0; hs_fail = 0; loop_fail = 0; st_trip = 0;
      ss_illegal_n = 1; cmd_bcast = 0;
   endtask

   task automatic cmd(input bit mode, input int code, input bit tr, input bit bc);
      cmd_valid = 1; cmd_mode = mode; cmd_code = 5'(code); cmd_tr = tr; cmd_bcast = bc;
      tick();
   endtask

   task automatic reset_rt();
      cmd(1, 8, 1, 0);
   endtask

   initial begin
      logic [15:0] saved;
      @(negedge clk);
      repeat (3) tick();
      chk("R1 reset word", bit_word, 0);
      chk("R1 reset msg_illegal", msg_illegal, 0);
      rst_n = 1;
      tick();

      bus0_off = 1; tick();
      chk("R2 bus0 shutdown", bit_word[8], 1);
      bus1_off = 1; tf_inhibit = 1; bus0_off = 0; tick();
      chk("R2 mirrors", bit_word[11:8], 4'b1010);
      bus1_off = 0; tf_inhibit = 0; tick();

      loop_fail = 1; tick();
      hs_fail = 1; tick();
      tx_timeout = 1; tx_bus = 1; tick();
      repeat (3) tick();
      chk("R3 sticky errors", bit_word, 16'h2007);
      tx_timeout = 1; tx_bus = 0; tick();
      chk("R3 bus0 timeout", bit_word[12], 1);
      reset_rt();
      chk("R10 reset-RT clears", bit_word, 0);

      cmd(1, 17, 1, 0);
      chk("R4 sync-with-data T/R", bit_word[3], 1);
      chk("R12 illegal T/R flag", msg_illegal, 1);
      cmd(1, 12, 0, 0);
      chk("R4 reserved code no T/R check", bit_word[3:4-1], 1);
      chk("R12 legal clears flag", msg_illegal, 0);
      reset_rt();

      ss_illegal_n = 0; cmd(0, 0, 0, 0);
      chk("R5 subsystem illegal", bit_word[4], 1);
      reset_rt();
      chk("R5 cleared by reset-RT", bit_word[4], 0);
      ss_allow_rsvd = 1; cmd(1, 25, 1, 0); ss_allow_rsvd = 0;
      chk("R5 reserved rejected", bit_word[4], 1);
      reset_rt();
      cmd(1, 25, 1, 0);
      chk("R5 reserved allowed", bit_word[4], 0);
      cmd(1, 20, 0, 0);
      chk("R5 selected shutdown", bit_word[4], 1);
      reset_rt();

      cmd(0, 0, 1, 1);
      chk("R6 broadcast transmit", bit_word[7], 1);
      reset_rt();
      cmd(0, 0, 0, 1);
      chk("R6 broadcast receive ok", bit_word[7], 0);
      cmd(1, 2, 1, 1);
      chk("R6 broadcast status read", bit_word[7], 1);
      reset_rt();

      msg_end = 1; rx_count = 3; exp_count = 5; tick();
      chk("R7 word count low", bit_word[6:5], 2'b01);
      cmd(0, 0, 0, 0);
      chk("R8 new command clears", bit_word[6:5], 2'b00);
      msg_end = 1; rx_count = 7; exp_count = 5; tick();
      chk("R7 word count high", bit_word[6:5], 2'b10);
      msg_end = 1; rx_count = 5; exp_count = 5; tick();
      chk("R7 exact count", bit_word[6:5], 2'b10);

      ss_illegal_n = 0; cmd(0, 0, 0, 0);
      msg_end = 1; rx_count = 9; exp_count = 2; tick();
      saved = bit_word;
      cmd(1, 2, 1, 0);
      chk("R9 status word read", bit_word, saved);
      cmd(1, 18, 1, 0);
      cmd(1, 19, 1, 0);
      chk("R9 last command and BIT read", bit_word, saved);
      chk("R9 msg_illegal held", msg_illegal, 1);

      cmd_valid = 1; cmd_mode = 0; cmd_tr = 0; cmd_code = 0;
      msg_end = 1; rx_count = 1; exp_count = 4; tick();
      chk("R8 clear and set same cycle", bit_word[6:5], 2'b01);
      cmd_valid = 1; cmd_mode = 1; cmd_code = 8; cmd_tr = 1; loop_fail = 1; tick();
      chk("R10 event survives reset-RT", bit_word, 16'h0004);
      reset_rt();

      cmd(1, 3, 1, 0);
      for (int i = 0; i < LO + 39; i++) tick();
      st_trip = 1; tick();
      repeat (5) tick();
      chk("R11 trip inside window", bit_word[0], 0);
      cmd(1, 3, 1, 0);
      for (int i = 0; i < 99; i++) tick();
      st_trip = 1; tick();
      chk("R11 trip too early", bit_word[0], 1);
      reset_rt();
      cmd(1, 3, 1, 0);
      for (int i = 0; i < HI - 1; i++) tick();
      chk("R11 before deadline", bit_word[0], 0);
      tick();
      chk("R11 no trip by deadline", bit_word[0], 1);
      chk("R1 constant zeros", {bit_word[15:14], bit_word[10]}, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule